// File: doc/BRIEF.md
# Pointer Address Generation Unit

This unit forms the data-memory address of a load or store and, where the addressing mode asks for it, the updated pointer that must go back to the register file. Each request carries an addressing mode, a 16-bit absolute address, a pointer select, a 6-bit unsigned offset and a snapshot of the six register-file bytes that make up the three 16-bit pointers. One clock edge after a request is accepted, the unit presents the address, a flag that lets the access go ahead, a write-back strobe with the pointer it refers to and its new value, and a flag for combinations that are not allowed.

Five modes are supported. In absolute mode the 16-bit address is used as it is, so the whole data space can be reached. In plain pointer mode the pointer itself is the address. In offset mode the address is a pointer plus the 6-bit offset, and only the two upper pointers may serve as the base. In the two auto-step modes the pointer changes by one and is written back. Pre-decrement uses the already stepped value as the address. Post-increment uses the value from before the step. All pointer arithmetic wraps modulo 2^16.

The register-file storage and the instruction decoder sit outside the unit. The decoder supplies the mode and the select codes. The register file supplies the bytes and accepts the write-back.

Top module: `agu_pointer_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, acc_en_o, wb_en_o and illegal_o are 0, and eff_addr_o, wb_ptr_o and wb_sel_o are 0.
- R2: Mode code 0 (absolute) gives eff_addr_o equal to direct_addr_i and acc_en_o=1 for any pointer select. wb_en_o is 0.
- R3: Mode code 1 (plain pointer) gives eff_addr_o equal to the selected pointer and acc_en_o=1. wb_en_o is 0.
- R4: Mode code 2 (offset) with select 1 or 2 gives eff_addr_o equal to the pointer plus the zero-extended offset and acc_en_o=1. wb_en_o is 0.
- R5: Mode code 3 (pre-decrement) gives eff_addr_o and wb_ptr_o both equal to the pointer minus one, wb_en_o=1, and wb_sel_o equal to the select.
- R6: Mode code 4 (post-increment) gives eff_addr_o equal to the unchanged pointer, wb_ptr_o equal to the pointer plus one, wb_en_o=1, and wb_sel_o equal to the select.
- R7: Pointer arithmetic wraps modulo 2^16. Stepping down from 0x0000 gives 0xFFFF, stepping up from 0xFFFF gives 0x0000, and an offset sum above 0xFFFF keeps its low 16 bits.
- R8: Select code 0 (X) is bytes 1:0 of ptr_bytes_i, code 1 (Y) is bytes 3:2 and code 2 (Z) is bytes 5:4. Byte k occupies bits 8k+7:8k, and the odd byte of each pair is the high byte.
- R9: Offset mode with select 0, any pointer mode (codes 1 to 4) with select 3, and mode codes 5 to 7 all give illegal_o=1 with acc_en_o=0, wb_en_o=0 and every data output 0.
- R10: The outputs reflect the request from the previous rising edge. A cycle without req_valid_i gives all outputs 0 on the following cycle. eff_addr_o is 0 whenever acc_en_o is 0, and wb_ptr_o and wb_sel_o are 0 whenever wb_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| mode_i | input | 3 | Addressing mode code, 0 to 4 legal |
| ptr_sel_i | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| direct_addr_i | input | 16 | Absolute address for mode 0 |
| disp_i | input | 6 | Unsigned offset for mode 2 |
| ptr_bytes_i | input | 48 | Six register-file bytes forming X, Y and Z |
| acc_en_o | output | 1 | The memory access may proceed |
| eff_addr_o | output | 16 | Effective data address |
| wb_en_o | output | 1 | Write the new pointer back |
| wb_sel_o | output | 2 | Pointer that the write-back targets |
| wb_ptr_o | output | 16 | New pointer value |
| illegal_o | output | 1 | Mode and select combination is not allowed |

## Verification
In the auto-step modes, address formation and pointer write-back happen in the same cycle, and the two must agree with each other. Pre-decrement must give an address equal to the written value. Post-increment must give an address one below it. The bench drives both modes with pointers at 0x0000 and 0xFFFF, where wrap-around hits the address and the write-back together, and mixes them with random requests. A behavioural integer model predicts every output field on every clock.

// File: rtl/agu_pkg.sv
package agu_pkg;

  parameter int unsigned BYTE_W  = 8;
  parameter int unsigned NUM_PTR = 3;
  parameter int unsigned DISP_W  = 6;
  localparam int unsigned AW     = 2 * BYTE_W;
  localparam int unsigned SEL_W  = $clog2(NUM_PTR + 1);
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT  = 3'd0,
    MODE_IND     = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_PREDEC  = 3'd3,
    MODE_POSTINC = 3'd4
  } agu_mode_e;

  localparam logic [SEL_W-1:0] SEL_X = 2'd0;

  typedef struct packed {
    logic          acc;
    logic          ill;
    logic          wb;
    logic [AW-1:0] addr;
    logic [AW-1:0] nptr;
  } agu_result_t;

  function automatic logic [AW-1:0] ptr_step_up(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_step_down(input logic [AW-1:0] p);
    return p - AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_offset(input logic [AW-1:0] p,
                                               input logic [DISP_W-1:0] d);
    return p + AW'(d);
  endfunction

endpackage

// File: rtl/agu_ptr_mux.sv
module agu_ptr_mux
  import agu_pkg::*;
(
  input  logic [2*NUM_PTR*BYTE_W-1:0] ptr_bytes_i,
  input  logic [SEL_W-1:0]            sel_i,
  output logic [AW-1:0]               ptr_o,
  output logic                        sel_ok_o
);

  logic [AW-1:0] pairs [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_pair
    assign pairs[g] = {ptr_bytes_i[(2*g+1)*BYTE_W +: BYTE_W],
                       ptr_bytes_i[(2*g)*BYTE_W   +: BYTE_W]};
  end

  always_comb begin
    ptr_o    = '0;
    sel_ok_o = 1'b0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (sel_i == SEL_W'(i)) begin
        ptr_o    = pairs[i];
        sel_ok_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              sel_ok_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [AW-1:0]     direct_i,
  input  logic [DISP_W-1:0] disp_i,
  output agu_result_t       res_o
);

  logic [AW-1:0] ptr_dn;
  logic [AW-1:0] ptr_up;
  logic [AW-1:0] ptr_off;
  logic          disp_base_ok;

  assign ptr_dn       = ptr_step_down(ptr_i);
  assign ptr_up       = ptr_step_up(ptr_i);
  assign ptr_off      = ptr_offset(ptr_i, disp_i);
  assign disp_base_ok = sel_ok_i && (sel_i != SEL_X);

  always_comb begin
    res_o = '0;
    unique case (mode_i)
      MODE_DIRECT: begin
        res_o.acc  = 1'b1;
        res_o.addr = direct_i;
      end
      MODE_IND: begin
        res_o.acc  = sel_ok_i;
        res_o.ill  = !sel_ok_i;
        res_o.addr = sel_ok_i ? ptr_i : '0;
      end
      MODE_DISP: begin
        res_o.acc  = disp_base_ok;
        res_o.ill  = !disp_base_ok;
        res_o.addr = disp_base_ok ? ptr_off : '0;
      end
      MODE_PREDEC: begin
        res_o.acc  = sel_ok_i;
        res_o.wb   = sel_ok_i;
        res_o.ill  = !sel_ok_i;
        res_o.addr = sel_ok_i ? ptr_dn : '0;
        res_o.nptr = sel_ok_i ? ptr_dn : '0;
      end
      MODE_POSTINC: begin
        res_o.acc  = sel_ok_i;
        res_o.wb   = sel_ok_i;
        res_o.ill  = !sel_ok_i;
        res_o.addr = sel_ok_i ? ptr_i : '0;
        res_o.nptr = sel_ok_i ? ptr_up : '0;
      end
      default: begin
        res_o.ill = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/agu_pointer_unit.sv
module agu_pointer_unit
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid_i,
  input  logic [2:0]  mode_i,
  input  logic [1:0]  ptr_sel_i,
  input  logic [15:0] direct_addr_i,
  input  logic [5:0]  disp_i,
  input  logic [47:0] ptr_bytes_i,
  output logic        acc_en_o,
  output logic [15:0] eff_addr_o,
  output logic        wb_en_o,
  output logic [1:0]  wb_sel_o,
  output logic [15:0] wb_ptr_o,
  output logic        illegal_o
);

  logic [AW-1:0] ptr_val;
  logic          sel_ok;
  agu_result_t   res;

  logic          wb_fire_w;
  logic          ill_fire_w;
  logic          acc_fire_w;

  agu_ptr_mux u_mux (
    .ptr_bytes_i (ptr_bytes_i),
    .sel_i       (ptr_sel_i),
    .ptr_o       (ptr_val),
    .sel_ok_o    (sel_ok)
  );

  agu_addr_calc u_calc (
    .mode_i   (mode_i),
    .sel_i    (ptr_sel_i),
    .sel_ok_i (sel_ok),
    .ptr_i    (ptr_val),
    .direct_i (direct_addr_i),
    .disp_i   (disp_i),
    .res_o    (res)
  );

  assign acc_fire_w = req_valid_i && res.acc;
  assign wb_fire_w  = req_valid_i && res.wb;
  assign ill_fire_w = req_valid_i && res.ill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_en_o   <= 1'b0;
      eff_addr_o <= '0;
      wb_en_o    <= 1'b0;
      wb_sel_o   <= '0;
      wb_ptr_o   <= '0;
      illegal_o  <= 1'b0;
    end else begin
      acc_en_o   <= acc_fire_w;
      eff_addr_o <= acc_fire_w ? res.addr : '0;
      wb_en_o    <= wb_fire_w;
      wb_sel_o   <= wb_fire_w ? ptr_sel_i : '0;
      wb_ptr_o   <= wb_fire_w ? res.nptr : '0;
      illegal_o  <= ill_fire_w;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid_i) |-> (!acc_en_o && !wb_en_o && !illegal_o)); // R10

  AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!acc_en_o && !wb_en_o && eff_addr_o == '0)); // R9

  AST_WB_ONLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> ($past(mode_i) == 3'(MODE_PREDEC) || $past(mode_i) == 3'(MODE_POSTINC))); // R5

  AST_PRE_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && $past(mode_i) == 3'(MODE_PREDEC)) |-> (eff_addr_o == wb_ptr_o)); // R5

  AST_POST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o && $past(mode_i) == 3'(MODE_POSTINC)) |-> (wb_ptr_o == 16'(eff_addr_o + 16'd1))); // R6

  AST_DISP_NOT_X: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_o && $past(mode_i) == 3'(MODE_DISP)) |-> ($past(ptr_sel_i) != SEL_X)); // R4

endmodule

// File: tb/tb_agu_pointer_unit.sv
module tb_agu_pointer_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  ptr_sel_i = '0;
  logic [15:0] direct_addr_i = '0;
  logic [5:0]  disp_i = '0;
  logic [47:0] ptr_bytes_i = '0;
  logic        acc_en_o;
  logic [15:0] eff_addr_o;
  logic        wb_en_o;
  logic [1:0]  wb_sel_o;
  logic [15:0] wb_ptr_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int e_acc, e_addr, e_wb, e_sel, e_ptr, e_ill;
  string e_tag;

  always #10 clk = ~clk;

  agu_pointer_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .mode_i(mode_i),
    .ptr_sel_i(ptr_sel_i), .direct_addr_i(direct_addr_i), .disp_i(disp_i),
    .ptr_bytes_i(ptr_bytes_i), .acc_en_o(acc_en_o), .eff_addr_o(eff_addr_o),
    .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o), .wb_ptr_o(wb_ptr_o),
    .illegal_o(illegal_o)
  );

  task automatic compare();
    checks++;
    if (acc_en_o !== 1'(e_acc) || eff_addr_o !== 16'(e_addr) || wb_en_o !== 1'(e_wb) ||
        wb_sel_o !== 2'(e_sel) || wb_ptr_o !== 16'(e_ptr) || illegal_o !== 1'(e_ill)) begin
      errors++;
      $display("FAIL %s: got acc=%0d addr=%h wb=%0d sel=%0d ptr=%h ill=%0d, expected acc=%0d addr=%h wb=%0d sel=%0d ptr=%h ill=%0d",
               e_tag, acc_en_o, eff_addr_o, wb_en_o, wb_sel_o, wb_ptr_o, illegal_o,
               e_acc, e_addr[15:0], e_wb, e_sel, e_ptr[15:0], e_ill);
    end
  endtask

  // Behavioural model: integers only, arithmetic taken mod 65536.
  task automatic predict(input bit v, input int m, input int s, input int dir,
                         input int d, input logic [47:0] regs, input string tag);
    int p;
    bit ok;
    e_acc = 0; e_addr = 0; e_wb = 0; e_sel = 0; e_ptr = 0; e_ill = 0;
    e_tag = tag;
    ok = (s < 3);
    p = ok ? (int'(regs[8*(2*s+1) +: 8]) * 256 + int'(regs[8*(2*s) +: 8])) : 0;
    if (v) begin
      if (m == 0) begin e_acc = 1; e_addr = dir; end
      else if (m > 4 || !ok || (m == 2 && s == 0)) e_ill = 1;
      else if (m == 1) begin e_acc = 1; e_addr = p; end
      else if (m == 2) begin e_acc = 1; e_addr = (p + d) % 65536; end
      else if (m == 3) begin
        e_acc = 1; e_wb = 1; e_sel = s;
        e_addr = (p + 65535) % 65536; e_ptr = e_addr;
      end else begin
        e_acc = 1; e_wb = 1; e_sel = s;
        e_addr = p; e_ptr = (p + 1) % 65536;
      end
    end
  endtask

  function automatic string mode_tag(input bit v, input int m, input int s);
    if (!v) return "R10";
    if (m > 4 || (m != 0 && s == 3) || (m == 2 && s == 0)) return "R9";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input bit v, input int m, input int s, input int dir,
                      input int d, input logic [47:0] regs, input string tag);
    @(negedge clk);
    compare();
    req_valid_i   = v;
    mode_i        = 3'(m);
    ptr_sel_i     = 2'(s);
    direct_addr_i = 16'(dir);
    disp_i        = 6'(d);
    ptr_bytes_i   = regs;
    predict(v, m, s, dir, d, regs, (tag == "") ? mode_tag(v, m, s) : tag);
  endtask

  initial begin
    e_acc = 0; e_addr = 0; e_wb = 0; e_sel = 0; e_ptr = 0; e_ill = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    checks++;
    if (acc_en_o !== 1'b0 || wb_en_o !== 1'b0 || illegal_o !== 1'b0 || eff_addr_o !== '0) begin
      errors++;
      $display("FAIL R1: in reset acc=%0d wb=%0d ill=%0d addr=%h, expected all 0",
               acc_en_o, wb_en_o, illegal_o, eff_addr_o);
    end
    rst_n = 1'b1;
    // R1: first post-reset cycle compared at the first step below.
    // Pointer bytes: X=0x1234, Y=0xBEEF, Z=0x0000.
    step(1, 0, 3, 16'hA5C3, 0, 48'h0000_BEEF_1234, "");   // R2
    step(1, 1, 0, 0, 0, 48'h0000_BEEF_1234, "");          // R3
    step(1, 1, 1, 0, 0, 48'h0000_BEEF_1234, "R8");        // R8 byte pairing Y
    step(1, 1, 2, 0, 0, 48'h7F80_BEEF_1234, "R8");        // R8 byte pairing Z
    step(1, 2, 1, 0, 63, 48'h0000_BEEF_1234, "");         // R4
    step(1, 2, 2, 0, 63, 48'hFFF0_0000_0000, "R7");       // R7 offset wrap
    step(1, 3, 2, 0, 0, 48'h0000_BEEF_1234, "R7");        // R7 0x0000 -> 0xFFFF
    step(1, 4, 1, 0, 0, 48'hFFFF_FFFF_1234, "R7");        // R7 0xFFFF -> 0x0000
    step(1, 3, 0, 0, 0, 48'h0000_BEEF_1234, "");          // R5
    step(1, 4, 0, 0, 0, 48'h0000_BEEF_1234, "");          // R6
    step(1, 2, 0, 0, 5, 48'h0000_BEEF_1234, "");          // R9 X with offset
    step(1, 4, 3, 0, 0, 48'h0000_BEEF_1234, "");          // R9 no pointer
    step(1, 6, 1, 0, 0, 48'h0000_BEEF_1234, "");          // R9 bad mode
    step(0, 3, 1, 0, 0, 48'h0000_BEEF_1234, "");          // R10 idle
    step(1, 3, 1, 0, 0, 48'h0000_BEEF_1234, "");          // R5 back to back
    step(1, 4, 2, 0, 0, 48'h0000_BEEF_1234, "");          // R6
    for (int i = 0; i < 400; i++) begin
      logic [47:0] r;
      r = {$urandom, $urandom};
      if (i % 7 == 0) r[47:32] = 16'hFFFF;
      if (i % 11 == 0) r[15:0] = 16'h0000;
      step(($urandom % 8) != 0, int'($urandom % 8), int'($urandom % 4),
           int'($urandom % 65536), int'($urandom % 64), r, "");
    end
    step(0, 0, 0, 0, 0, '0, "");
    step(0, 0, 0, 0, 0, '0, "");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule